// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Controller

This block arbitrates interrupts for a set of device slots. All slots share one combined request line toward the processor, and they sit on a serial acknowledge chain. When the processor acknowledges, the pulse enters the slot nearest the processor. Each slot that is not requesting passes the pulse on. The first requesting slot keeps the pulse, receives its own acknowledge output, and puts its identity code on the vector bus in the same cycle. A device deasserts its request once it has been acknowledged.

The slots are divided into equal priority groups. The block keeps a stack of the groups currently in service. A new acknowledge can reach only a device whose group has strictly higher priority than the group on top of the stack. An end-of-service pulse pops that group, so service of a higher group can nest inside service of a lower one. While a service routine runs with the interrupt-enable input low, acknowledges are ignored. Priority is fixed by position. A device far down the chain can therefore be starved for as long as higher devices keep requesting.

Top module: `daisy_irq_ctrl`

## Requirements
- R1: `irq_line` is high in exactly the cycles where at least one bit of `dev_req` is high, whatever the state of enable, acknowledge or the service stack.
- R2: When `cpu_ack` and `int_en` are both high, `dev_ack` has a single bit set in that same cycle. That bit is the lowest-index requesting device whose group is eligible. Index 0 has the highest priority.
- R3: `vec` equals the acknowledged device's index plus one in the cycle of its acknowledge. It is 0 in every cycle where no device is acknowledged.
- R4: When `cpu_ack` is low, or when `int_en` is low, `dev_ack` is all zero and `vec` is 0.
- R5: A device whose request is low passes the acknowledge on. A request withdrawn before the acknowledge lets it fall through to the next requester. If no eligible requester is left, `vec` is 0 and the service stack does not change.
- R6: Device i belongs to group i/(NUM_DEV/NUM_GRP), and group 0 has the highest priority. Each acknowledge pushes the device's group. While the stack is non-empty, only devices in a group numbered strictly lower than the top entry can be acknowledged.
- R7: A cycle with `eos` high pops the top group, which restores the eligibility of the level below it. `eos` on an empty stack has no effect.
- R8: Nesting reaches a depth of NUM_GRP. When `eos` and an acknowledge fall in the same cycle, eligibility uses the current top, and the new group replaces that top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties the service stack |
| dev_req | input | NUM_DEV | Request from each device slot |
| dev_ack | output | NUM_DEV | Acknowledge to each device slot |
| irq_line | output | 1 | Combined request toward the processor |
| cpu_ack | input | 1 | Single-cycle acknowledge pulse from the processor |
| int_en | input | 1 | Processor interrupt enable |
| eos | input | 1 | End-of-service pulse |
| vec | output | clog2(NUM_DEV+1) | Identity code of the acknowledged device, 0 for none |

## Verification
The checker watches every cycle for the following. At most one acknowledge is out at a time, and it goes only to a requesting device. The vector is zero exactly when no acknowledge is out. Acknowledges are absent while masked. A granted group always outranks the stack top. The stack depth changes by one on each push and each pop and never exceeds the group count. Whether the chosen device is truly the lowest-index eligible requester can be shown only by the bench's stimulus patterns. The same holds for the fall-through after a withdrawn request and for the exact group order restored by a chain of pops. The bench also checks the same-cycle pop-and-grant case by probing eligibility after it.

// File: rtl/daisy_irq_ctrl.sv
module daisy_irq_ctrl #(
  parameter int NUM_DEV = 8,
  parameter int NUM_GRP = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_DEV-1:0]             dev_req,
  output logic [NUM_DEV-1:0]             dev_ack,
  output logic                           irq_line,
  input  logic                           cpu_ack,
  input  logic                           int_en,
  input  logic                           eos,
  output logic [$clog2(NUM_DEV+1)-1:0]   vec
);
  localparam int DPG   = NUM_DEV / NUM_GRP;
  localparam int VEC_W = $clog2(NUM_DEV + 1);
  localparam int GW    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int DW    = $clog2(NUM_GRP + 1);

  logic [GW-1:0]      stk [NUM_GRP];
  logic [DW-1:0]      lvl_cnt;
  logic [GW-1:0]      top_grp;
  logic [NUM_GRP-1:0] grp_ok;
  logic [NUM_DEV-1:0] elig;
  logic [NUM_DEV-1:0] pass;
  logic [GW-1:0]      gnt_grp;
  logic               granted;
  logic               pop;
  logic [DW-1:0]      wr_idx;

  assign irq_line = |dev_req;

  always_comb begin
    top_grp = '0;
    for (int k = 0; k < NUM_GRP; k++)
      if (DW'(k + 1) == lvl_cnt) top_grp = stk[k];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_ok[g] = (lvl_cnt == '0) || (GW'(g) < top_grp);
  end

  assign pass[0] = cpu_ack & int_en;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_chain
    assign elig[i]    = dev_req[i] & grp_ok[i / DPG];
    assign dev_ack[i] = pass[i] & elig[i];
    if (i < NUM_DEV - 1) begin : g_link
      assign pass[i+1] = pass[i] & ~elig[i];
    end
  end

  always_comb begin
    vec     = '0;
    gnt_grp = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (dev_ack[i]) begin
        vec     = VEC_W'(i + 1);
        gnt_grp = GW'(i / DPG);
      end
  end

  assign granted = |dev_ack;
  assign pop     = eos && (lvl_cnt != '0);
  assign wr_idx  = pop ? lvl_cnt - 1'b1 : lvl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_cnt <= '0;
      for (int k = 0; k < NUM_GRP; k++) stk[k] <= '0;
    end else begin
      lvl_cnt <= lvl_cnt + DW'(granted) - DW'(pop);
      for (int k = 0; k < NUM_GRP; k++)
        if (granted && DW'(k) == wr_idx) stk[k] <= gnt_grp;
    end
  end
endmodule

// File: rtl/daisy_irq_chk.sv
module daisy_irq_chk #(
  parameter int NUM_DEV = 8,
  parameter int NUM_GRP = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_DEV-1:0]            dev_req,
  input logic [NUM_DEV-1:0]            dev_ack,
  input logic                          cpu_ack,
  input logic                          int_en,
  input logic                          eos,
  input logic [$clog2(NUM_DEV+1)-1:0]  vec,
  input logic [$clog2(NUM_GRP+1)-1:0]  lvl_cnt,
  input logic [((NUM_GRP > 1) ? $clog2(NUM_GRP) : 1)-1:0] top_grp
);
  localparam int DPG = NUM_DEV / NUM_GRP;
  localparam int GW  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [GW-1:0] ack_grp;
  always_comb begin
    ack_grp = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (dev_ack[i]) ack_grp = GW'(i / DPG);
  end

  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));

  assert_ack_to_requester_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack & ~dev_req) == '0);

  assert_vec_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack == '0) |-> (vec == '0));

  assert_vec_some_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack != '0) |-> (vec != '0));

  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && int_en) |-> (dev_ack == '0));

  assert_nest_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_ack != '0) && (lvl_cnt != '0)) |-> (ack_grp < top_grp));

  assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && (lvl_cnt != '0) && (dev_ack == '0)) |=> (lvl_cnt == $past(lvl_cnt) - 1'b1));

  assert_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_ack != '0) && !eos) |=> (lvl_cnt == $past(lvl_cnt) + 1'b1));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_cnt <= NUM_GRP);
endmodule

bind daisy_irq_ctrl daisy_irq_chk #(.NUM_DEV(NUM_DEV), .NUM_GRP(NUM_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
  .cpu_ack(cpu_ack), .int_en(int_en), .eos(eos), .vec(vec),
  .lvl_cnt(lvl_cnt), .top_grp(top_grp)
);

// File: tb/tb_daisy_irq_ctrl.sv
`timescale 1ns/1ps
module tb_daisy_irq_ctrl;
  localparam int ND = 8;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ND-1:0] dev_req = '0;
  logic [ND-1:0] dev_ack;
  logic          irq_line;
  logic          cpu_ack = 1'b0;
  logic          int_en = 1'b1;
  logic          eos = 1'b0;
  logic [3:0]    vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  daisy_irq_ctrl #(.NUM_DEV(ND), .NUM_GRP(NG)) dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
    .irq_line(irq_line), .cpu_ack(cpu_ack), .int_en(int_en), .eos(eos), .vec(vec)
  );

  // fields: req, ack, en, exp_ack, exp_vec, exp_irq
  localparam logic [22:0] TBL [0:9] = '{
    {8'h00, 1'b0, 1'b1, 8'h00, 4'd0, 1'b0},
    {8'h01, 1'b1, 1'b1, 8'h01, 4'd1, 1'b1},
    {8'h80, 1'b1, 1'b1, 8'h80, 4'd8, 1'b1},
    {8'hA4, 1'b1, 1'b1, 8'h04, 4'd3, 1'b1},
    {8'hFF, 1'b1, 1'b0, 8'h00, 4'd0, 1'b1},
    {8'h30, 1'b0, 1'b1, 8'h00, 4'd0, 1'b1},
    {8'h18, 1'b1, 1'b1, 8'h08, 4'd4, 1'b1},
    {8'h60, 1'b1, 1'b1, 8'h20, 4'd6, 1'b1},
    {8'h00, 1'b1, 1'b1, 8'h00, 4'd0, 1'b0},
    {8'hC0, 1'b1, 1'b1, 8'h40, 4'd7, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ND-1:0] ack_of(input int v);
    return (v == 0) ? '0 : (ND'(1) << (v - 1));
  endfunction

  task automatic try_ack(input logic [ND-1:0] req, input int exp_v, input string tag);
    @(negedge clk);
    dev_req = req;
    cpu_ack = 1'b1;
    #1;
    check({tag, " vec"}, int'(vec), exp_v);
    check({tag, " dev_ack"}, int'(dev_ack), int'(ack_of(exp_v)));
    @(negedge clk);
    cpu_ack = 1'b0;
    dev_req = '0;
  endtask

  task automatic end_service();
    @(negedge clk);
    eos = 1'b1;
    @(negedge clk);
    eos = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset irq_line", int'(irq_line), 0);
    check("R3 reset vec", int'(vec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R4 reset dev_ack", int'(dev_ack), 0);

    // table walk: stack starts empty each row (grants are closed by an end of service)
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      dev_req = TBL[n][22:15];
      cpu_ack = TBL[n][14];
      int_en  = TBL[n][13];
      #1;
      check($sformatf("R2 row%0d dev_ack", n), int'(dev_ack), int'(TBL[n][12:5]));
      check($sformatf("R3 row%0d vec", n), int'(vec), int'(TBL[n][4:1]));
      check($sformatf("R1 row%0d irq_line", n), int'(irq_line), int'(TBL[n][0]));
      @(negedge clk);
      cpu_ack = 1'b0;
      dev_req = '0;
      int_en  = 1'b1;
      if (TBL[n][4:1] != 0) end_service();
    end

    // R5: withdrawn request before the acknowledge falls through
    @(negedge clk);
    dev_req = 8'h06;
    @(negedge clk);
    dev_req = 8'h04;
    cpu_ack = 1'b1;
    #1;
    check("R5 fall-through vec", int'(vec), 3);
    check("R5 fall-through dev_ack", int'(dev_ack), 8'h04);
    @(negedge clk);
    cpu_ack = 1'b0;
    dev_req = '0;
    end_service();
    // R5: empty acknowledge leaves stack unchanged: group-3 device still grantable
    try_ack(8'h00, 0, "R5 no requester");
    try_ack(8'h80, 8, "R5 stack untouched");
    end_service();

    // R6/R7 nesting
    try_ack(8'h40, 7, "R6 base g3");
    try_ack(8'h90, 5, "R6 nest g2 over g3");
    try_ack(8'h20, 0, "R6 same group blocked");
    try_ack(8'h80, 0, "R6 lower group blocked");
    try_ack(8'h02, 2, "R6 nest g0 over g2");
    try_ack(8'h01, 0, "R6 g0 under g0 blocked");
    end_service();
    try_ack(8'h20, 0, "R7 top back to g2");
    end_service();
    try_ack(8'h20, 6, "R7 top back to g3");
    end_service();
    end_service();
    end_service();
    try_ack(8'h80, 8, "R7 empty after pops");
    end_service();

    // R4: masked by enable during service
    @(negedge clk);
    dev_req = 8'h01;
    int_en = 1'b0;
    cpu_ack = 1'b1;
    #1;
    check("R4 masked vec", int'(vec), 0);
    check("R1 masked irq_line", int'(irq_line), 1);
    @(negedge clk);
    cpu_ack = 1'b0;
    int_en = 1'b1;
    dev_req = '0;
    try_ack(8'h80, 8, "R4 masked ack pushed nothing");
    end_service();

    // R8: end of service and grant in the same cycle
    try_ack(8'h40, 7, "R8 base g3");
    @(negedge clk);
    dev_req = 8'h04;
    cpu_ack = 1'b1;
    eos = 1'b1;
    #1;
    check("R8 same-cycle grant vec", int'(vec), 3);
    @(negedge clk);
    cpu_ack = 1'b0;
    eos = 1'b0;
    dev_req = '0;
    try_ack(8'h10, 0, "R8 top replaced by g1");
    end_service();
    try_ack(8'h80, 8, "R8 stack empty after replace");
    end_service();

    // R8: full depth
    try_ack(8'h40, 7, "R8 depth1");
    try_ack(8'h10, 5, "R8 depth2");
    try_ack(8'h08, 4, "R8 depth3");
    try_ack(8'h01, 1, "R8 depth4");
    try_ack(8'h02, 0, "R8 full stack blocks g0");
    for (int k = 0; k < 4; k++) end_service();
    try_ack(8'h80, 8, "R8 unwound");
    end_service();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule